// File: doc/BRIEF.md
# I2C Bit-Level Command Sequencer

This block carries out one I2C bit operation at a time for a byte-level controller sitting above it. The operations are START, repeated START, STOP, write one bit and read one bit. Each accepted operation is split into equal timed steps. The step length is set by a 16-bit prescale value. SCL and SDA are driven open-drain: the data outputs stay at zero, and active-low enables pull a line low or release it.

Both bus inputs are synchronised and then cleaned by a two-of-three majority window. The block waits while a slave holds SCL low after the block has released it. It watches the bus for START and STOP conditions to keep a busy flag. While writing a 1, it compares the SDA level on the bus with its own drive to detect lost arbitration.

The caller places a command code on `cmd` and asserts `cmd_valid` for one clock while the block is idle. It then waits for a one-clock `done` pulse, or for `arb_lost`. The prescale bus is normally fed from a low-byte and a high-byte register. An SCL period lasts about 5·(prescale+1) system clocks.

Top module: `i2c_bitseq`

## Requirements
- R1: After reset, `scl_oen` and `sda_oen` are 1 (lines released) and `done`, `busy` and `arb_lost` are 0. `scl_o` and `sda_o` are 0 at all times.
- R2: Command codes are 1 = START (also used as repeated START), 2 = STOP, 3 = WRITE and 4 = READ. A command is taken only when `cmd_valid` is 1 in the idle state. Code 0, codes 5 to 7 and any command offered while an operation runs have no effect.
- R3: START, WRITE and READ pass through one lead step and four phases, A to D. STOP passes through one lead step and three phases, A to C. Each step lasts prescale+1 clocks. `done` is a single-clock pulse in the cycle after the final step ends. A START issued with SCL high gives `done` 5·(prescale+1) clocks after the accepting edge.
- R4: While the block has released SCL but the filtered SCL is low, step timing is frozen. Releasing SCL from low therefore costs the 4-clock filter delay. A slave that keeps SCL low lengthens the operation by exactly the extra time it holds the line.
- R5: WRITE pulls SCL low in the lead step, sets SDA to `din` (released for 1), raises SCL in phases B and C, and pulls SCL low in D. At `done`, `sda_oen` equals `din`. A WRITE with SCL initially low takes 5·(prescale+1)+4 clocks.
- R6: READ keeps SDA released. It samples the filtered SDA at the end of phase C and presents the bit on `dout` when `done` is high. It takes 5·(prescale+1)+4 clocks.
- R7: During a WRITE of 1, if SDA is seen low while SCL is seen high in phase C, `arb_lost` pulses for one clock instead of `done`. In that same cycle both lines are released and the block is idle and ready for a new command. With SCL low at the start, the pulse falls 3·(prescale+1)+5 clocks after the accepting edge.
- R8: Each input passes two synchroniser flops and a three-sample majority window, 4 clocks of delay in total. A low pulse of one clock on SDA changes nothing.
- R9: An SDA fall while SCL is high (START) sets `busy`. An SDA rise while SCL is high (STOP) clears it. This holds whether the conditions come from this block or from another device.
- R10: A repeated START issued with SCL low takes 5·(prescale+1)+4 clocks and leaves `busy` set.
- R11: A STOP issued with SCL low takes 4·(prescale+1)+4 clocks and afterwards `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale | input | 16 | Step length minus one, in clocks |
| cmd_valid | input | 1 | Command request strobe |
| cmd | input | 3 | Command code |
| din | input | 1 | Bit to write |
| scl_i | input | 1 | SCL level seen on the bus |
| sda_i | input | 1 | SDA level seen on the bus |
| scl_o | output | 1 | SCL output data, always 0 |
| scl_oen | output | 1 | SCL enable, 0 pulls low |
| sda_o | output | 1 | SDA output data, always 0 |
| sda_oen | output | 1 | SDA enable, 0 pulls low |
| done | output | 1 | One-clock end-of-operation pulse |
| dout | output | 1 | Bit sampled by READ |
| busy | output | 1 | Bus held between START and STOP |
| arb_lost | output | 1 | One-clock arbitration loss pulse |

## Verification
Results are counted from the clock edge that accepts the command. `done` is due after (steps)·(prescale+1) clocks, plus 4 whenever the operation releases SCL from low, plus any extra time a slave holds SCL low. `arb_lost` is due one clock after the first cycle of phase C. `busy` changes 5 clocks after the SDA edge on the bus. The bench drives each command on a falling edge and counts falling edges until `done` or `arb_lost` appears, then compares that count with the formula for each prescale value from 0 to 3. Flag checks wait ten idle clocks so that the 4-clock filter delay and the detector register have settled.

// File: rtl/i2c_bs_pkg.sv
package i2c_bs_pkg;

  typedef enum logic [2:0] {
    OP_NONE  = 3'd0,
    OP_START = 3'd1,
    OP_STOP  = 3'd2,
    OP_WRITE = 3'd3,
    OP_READ  = 3'd4
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_A    = 3'd2,
    ST_B    = 3'd3,
    ST_C    = 3'd4,
    ST_D    = 3'd5
  } step_e;

  // 1 = released, 0 = pulled low
  typedef struct packed {
    logic scl_rel;
    logic sda_rel;
  } lines_t;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[0] & v[2]) | (v[1] & v[2]);
  endfunction

  function automatic logic op_known(input logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd4);
  endfunction

  // Step that follows st; ST_IDLE marks the end of the operation.
  function automatic step_e step_after(input op_e op, input step_e st);
    case (st)
      ST_LEAD: return ST_A;
      ST_A:    return ST_B;
      ST_B:    return ST_C;
      ST_C:    return (op == OP_STOP) ? ST_IDLE : ST_D;
      default: return ST_IDLE;
    endcase
  endfunction

  // Line drive applied on entry into step st.
  function automatic lines_t step_lines(input op_e op, input step_e st,
                                        input logic din, input lines_t cur);
    lines_t r;
    logic   b;
    r = cur;
    b = (op == OP_READ) ? 1'b1 : din;
    case (op)
      OP_START: begin
        case (st)
          ST_LEAD:    r.sda_rel = 1'b1;
          ST_A, ST_B: r = '{scl_rel: 1'b1, sda_rel: 1'b1};
          ST_C:       r = '{scl_rel: 1'b1, sda_rel: 1'b0};
          ST_D:       r = '{scl_rel: 1'b0, sda_rel: 1'b0};
          default:    r = cur;
        endcase
      end
      OP_STOP: begin
        case (st)
          ST_LEAD:    r.sda_rel = 1'b0;
          ST_A, ST_B: r = '{scl_rel: 1'b1, sda_rel: 1'b0};
          ST_C:       r = '{scl_rel: 1'b1, sda_rel: 1'b1};
          default:    r = cur;
        endcase
      end
      OP_WRITE, OP_READ: begin
        case (st)
          ST_LEAD, ST_A, ST_D: r = '{scl_rel: 1'b0, sda_rel: b};
          ST_B, ST_C:          r = '{scl_rel: 1'b1, sda_rel: b};
          default:             r = cur;
        endcase
      end
      default: r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2c_bs_filt.sv
module i2c_bs_filt
  import i2c_bs_pkg::*;
#(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int WIN = 3;

  logic [SYNC-1:0] sync_q;
  logic [WIN-1:0]  win_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      win_q  <= '1;
    end else begin
      sync_q <= {sync_q[SYNC-2:0], raw};
      win_q  <= {win_q[WIN-2:0], sync_q[SYNC-1]};
    end
  end

  assign filt = maj3(win_q);
endmodule

// File: rtl/i2c_bs_tick.sv
module i2c_bs_tick #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          hold,
  input  logic [PW-1:0] prescale,
  output logic          tick
);
  logic [PW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart)         cnt_q <= prescale;
    else if (hold)            cnt_q <= cnt_q;
    else if (cnt_q == '0)     cnt_q <= prescale;
    else                      cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0) && !hold && !restart;
endmodule

// File: rtl/i2c_bs_cond.sv
module i2c_bs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic start_det,
  output logic stop_det,
  output logic busy
);
  logic scl_p, sda_p, busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
      busy_q <= 1'b0;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
    end
  end

  assign start_det = scl_f && scl_p && sda_p && !sda_f;
  assign stop_det  = scl_f && scl_p && !sda_p && sda_f;
  assign busy      = busy_q;
endmodule

// File: rtl/i2c_bitseq.sv
module i2c_bitseq
  import i2c_bs_pkg::*;
#(
  parameter int PRESC_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PRESC_W-1:0] prescale,
  input  logic               cmd_valid,
  input  logic [2:0]         cmd,
  input  logic               din,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               scl_o,
  output logic               scl_oen,
  output logic               sda_o,
  output logic               sda_oen,
  output logic               done,
  output logic               dout,
  output logic               busy,
  output logic               arb_lost
);
  localparam int NLINES  = 2;
  localparam int IDX_SDA = 0;
  localparam int IDX_SCL = 1;

  // input conditioning
  logic [NLINES-1:0] raw_v, filt_v;
  logic              scl_f, sda_f;
  assign raw_v = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_filt
    i2c_bs_filt #(.SYNC(SYNC_STAGES)) u_filt (
      .clk  (clk),
      .rst_n(rst_n),
      .raw  (raw_v[g]),
      .filt (filt_v[g])
    );
  end
  assign scl_f = filt_v[IDX_SCL];
  assign sda_f = filt_v[IDX_SDA];

  // sequencer state
  step_e  st_q;
  op_e    op_q;
  logic   din_q;
  lines_t lines_q;
  logic   done_q, dout_q, arb_q;

  // named events
  logic  accept, seq_active, stretch_hold, tick, arb_hit;
  logic  start_det, stop_det;
  step_e nxt;

  assign accept       = (st_q == ST_IDLE) && cmd_valid && op_known(cmd);
  assign seq_active   = (st_q != ST_IDLE);
  assign stretch_hold = seq_active && lines_q.scl_rel && !scl_f;
  assign arb_hit      = (st_q == ST_C) && (op_q == OP_WRITE) && din_q && scl_f && !sda_f;
  assign nxt          = step_after(op_q, st_q);

  i2c_bs_tick #(.PW(PRESC_W)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (accept),
    .hold    (stretch_hold),
    .prescale(prescale),
    .tick    (tick)
  );

  i2c_bs_cond u_cond (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .start_det(start_det),
    .stop_det (stop_det),
    .busy     (busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      op_q    <= OP_NONE;
      din_q   <= 1'b0;
      lines_q <= '{scl_rel: 1'b1, sda_rel: 1'b1};
      done_q  <= 1'b0;
      dout_q  <= 1'b0;
      arb_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      arb_q  <= 1'b0;
      if (arb_hit) begin
        st_q    <= ST_IDLE;
        lines_q <= '{scl_rel: 1'b1, sda_rel: 1'b1};
        arb_q   <= 1'b1;
      end else if (accept) begin
        st_q    <= ST_LEAD;
        op_q    <= op_e'(cmd);
        din_q   <= din;
        lines_q <= step_lines(op_e'(cmd), ST_LEAD, din, lines_q);
      end else if (seq_active && tick) begin
        if ((st_q == ST_C) && (op_q == OP_READ)) dout_q <= sda_f;
        st_q <= nxt;
        if (nxt == ST_IDLE) done_q  <= 1'b1;
        else                lines_q <= step_lines(op_q, nxt, din_q, lines_q);
      end
    end
  end

  assign scl_o    = 1'b0;
  assign sda_o    = 1'b0;
  assign scl_oen  = lines_q.scl_rel;
  assign sda_oen  = lines_q.sda_rel;
  assign done     = done_q;
  assign dout     = dout_q;
  assign arb_lost = arb_q;
endmodule

// File: rtl/i2c_bs_chk.sv
module i2c_bs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       done,
  input logic       arb_lost,
  input logic       scl_oen,
  input logic       sda_oen,
  input logic       busy,
  input logic       start_det,
  input logic       stop_det,
  input logic       seq_active,
  input logic       stretch_hold,
  input logic       cmd_valid,
  input logic [2:0] st_code,
  input logic [2:0] op_code
);
  AST_DONE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R3

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(seq_active)); // R3

  AST_ARB_RELEASES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |-> (scl_oen && sda_oen && !seq_active)); // R7

  AST_ARB_NOT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !(arb_lost && done)); // R7

  AST_STRETCH_FREEZES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    stretch_hold |=> (st_code == $past(st_code))); // R4

  AST_CMD_IGNORED_WHILE_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && cmd_valid) |=> (op_code == $past(op_code))); // R2

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> busy); // R9

  AST_BUSY_OFF_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> !busy); // R9
endmodule

bind i2c_bitseq i2c_bs_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .done        (done),
  .arb_lost    (arb_lost),
  .scl_oen     (scl_oen),
  .sda_oen     (sda_oen),
  .busy        (busy),
  .start_det   (start_det),
  .stop_det    (stop_det),
  .seq_active  (seq_active),
  .stretch_hold(stretch_hold),
  .cmd_valid   (cmd_valid),
  .st_code     (st_q),
  .op_code     (op_q)
);

// File: tb/i2c_bitseq_bench.sv
module i2c_bitseq_bench;
  localparam logic [2:0] C_START = 3'd1, C_STOP = 3'd2, C_WRITE = 3'd3, C_READ = 3'd4;
  localparam int FILT = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] prescale = 16'd0;
  logic cmd_valid = 1'b0, din = 1'b0;
  logic [2:0] cmd = 3'd0;
  logic scl_o, scl_oen, sda_o, sda_oen, done, dout, busy, arb_lost;
  logic slv_scl_low = 1'b0, slv_sda_low = 1'b0;
  logic scl_pin, sda_pin;

  assign scl_pin = scl_oen & ~slv_scl_low;
  assign sda_pin = sda_oen & ~slv_sda_low;

  always #10 clk = ~clk;

  i2c_bitseq u_i2c_bitseq (
    .clk(clk), .rst_n(rst_n), .prescale(prescale), .cmd_valid(cmd_valid),
    .cmd(cmd), .din(din), .scl_i(scl_pin), .sda_i(sda_pin),
    .scl_o(scl_o), .scl_oen(scl_oen), .sda_o(sda_o), .sda_oen(sda_oen),
    .done(done), .dout(dout), .busy(busy), .arb_lost(arb_lost)
  );

  int errs = 0, nchk = 0;
  int got_lat;
  logic got_done, got_arb;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nchk++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Counts falling edges from the accepting edge until done or arb_lost.
  task automatic run_op(input logic [2:0] c, input logic d);
    @(negedge clk);
    cmd = c; din = d; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cmd = 3'd0;
    got_lat = 0;
    while (!done && !arb_lost && got_lat < 2000) begin
      @(negedge clk);
      got_lat++;
    end
    got_done = done;
    got_arb  = arb_lost;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++; nchk++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    int u;
    logic [7:0] wpat, rpat;

    idle(3);
    // R1 reset state
    chk(scl_oen === 1'b1 && sda_oen === 1'b1, "R1", "lines released", {scl_oen, sda_oen}, 3);
    chk(done === 1'b0 && busy === 1'b0 && arb_lost === 1'b0, "R1", "flags", {done, busy, arb_lost}, 0);
    chk(scl_o === 1'b0 && sda_o === 1'b0, "R1", "pad data", {scl_o, sda_o}, 0);
    rst_n = 1'b1;
    idle(3);

    // R2 unknown code ignored
    prescale = 16'd1;
    @(negedge clk); cmd = 3'd6; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0; cmd = 3'd0;
    got_lat = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (done || !scl_oen || !sda_oen) got_lat++;
    end
    chk(got_lat == 0, "R2", "code 6 had effect", got_lat, 0);

    // Sweep over prescale values
    for (int p = 0; p < 4; p++) begin
      prescale = 16'(p);
      u = p + 1;
      wpat = 8'hA5 ^ 8'(p * 8'h3C);
      rpat = 8'h5C ^ 8'(p * 8'h27);

      run_op(C_START, 1'b0);
      chk(got_done && got_lat == 5 * u, "R3", "START latency", got_lat, 5 * u);
      idle(10);
      chk(busy === 1'b1, "R9", "busy after START", busy, 1);

      for (int b = 7; b >= 0; b--) begin
        run_op(C_WRITE, wpat[b]);
        chk(got_done && got_lat == 5 * u + FILT, "R5", "WRITE latency", got_lat, 5 * u + FILT);
        chk(sda_oen === wpat[b], "R5", "SDA drive", sda_oen, wpat[b]);
      end

      run_op(C_START, 1'b0);
      chk(got_done && got_lat == 5 * u + FILT, "R10", "repeated START latency", got_lat, 5 * u + FILT);
      idle(10);
      chk(busy === 1'b1, "R10", "busy after repeated START", busy, 1);

      for (int b = 7; b >= 0; b--) begin
        slv_sda_low = ~rpat[b];
        run_op(C_READ, 1'b0);
        chk(got_done && got_lat == 5 * u + FILT, "R6", "READ latency", got_lat, 5 * u + FILT);
        chk(dout === rpat[b], "R6", "READ bit", dout, rpat[b]);
        slv_sda_low = 1'b0;
      end

      run_op(C_STOP, 1'b0);
      chk(got_done && got_lat == 4 * u + FILT, "R11", "STOP latency", got_lat, 4 * u + FILT);
      idle(10);
      chk(busy === 1'b0, "R11", "busy after STOP", busy, 0);
    end

    // Clock stretching and a command offered mid-run
    prescale = 16'd1; u = 2;
    run_op(C_START, 1'b0);
    chk(got_done && got_lat == 5 * u, "R3", "START latency", got_lat, 5 * u);
    idle(2);
    slv_scl_low = 1'b1;
    fork
      run_op(C_WRITE, 1'b0);
      begin
        @(negedge clk);
        repeat (2 * u + 7 + 1) @(negedge clk);
        slv_scl_low = 1'b0;
      end
      begin
        @(negedge clk);
        repeat (3) @(negedge clk);
        cmd = C_STOP; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd = 3'd0;
      end
    join
    chk(got_done && got_lat == 5 * u + FILT + 7, "R4", "stretched WRITE latency", got_lat, 5 * u + FILT + 7);
    idle(10);
    chk(scl_oen === 1'b0, "R2", "STOP offered mid-run ran", scl_oen, 0);
    chk(busy === 1'b1, "R2", "busy after ignored STOP", busy, 1);

    run_op(C_STOP, 1'b0);
    chk(got_done && got_lat == 4 * u + FILT, "R11", "STOP latency", got_lat, 4 * u + FILT);
    idle(10);

    // Glitch filtering on a free bus
    @(negedge clk); slv_sda_low = 1'b1;
    @(negedge clk); slv_sda_low = 1'b0;
    idle(10);
    chk(busy === 1'b0, "R8", "one-clock glitch seen as START", busy, 0);
    @(negedge clk); slv_sda_low = 1'b1;
    idle(8);
    chk(busy === 1'b1, "R8", "long SDA low not seen as START", busy, 1);
    slv_sda_low = 1'b0;
    idle(10);
    chk(busy === 1'b0, "R9", "foreign STOP clears busy", busy, 0);

    // Arbitration loss
    run_op(C_START, 1'b0);
    chk(got_done && got_lat == 5 * u, "R3", "START latency", got_lat, 5 * u);
    idle(2);
    slv_sda_low = 1'b1;
    run_op(C_WRITE, 1'b1);
    chk(got_arb && !got_done, "R7", "arb_lost without done", {got_arb, got_done}, 2);
    chk(got_lat == 3 * u + 5, "R7", "arb_lost timing", got_lat, 3 * u + 5);
    chk(scl_oen === 1'b1 && sda_oen === 1'b1, "R7", "lines released", {scl_oen, sda_oen}, 3);
    @(negedge clk);
    chk(arb_lost === 1'b0, "R7", "arb_lost one clock", arb_lost, 0);
    slv_sda_low = 1'b0;
    idle(10);
    chk(busy === 1'b0, "R9", "busy after foreign STOP", busy, 0);
    run_op(C_START, 1'b0);
    chk(got_done && got_lat == 5 * u, "R7", "START after arbitration loss", got_lat, 5 * u);
    run_op(C_STOP, 1'b0);
    chk(got_done && got_lat == 4 * u + FILT, "R11", "STOP latency", got_lat, 4 * u + FILT);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule